// File: doc/BRIEF.md
# Three-Wire Serial Byte Shifter

This block is the master side of a three-wire link to a serial clock/calendar device. The wires are a clock line, a data output with its own output enable, and a data input. Together the last two form one shared bidirectional data wire. A higher-level sequencer pulses `start_i` with a direction flag and a transmit byte. The block then moves one byte over the wire and pulses `done_o`. For a read, the received value appears on `rdata_o`.

Every bit uses half-periods whose length is a parameter. The parameter is derived from the system clock frequency and a nominal 700 ns half-period. On a write, each bit value is set up while the clock is high, then the clock is pulsed low and back high. On a read, the block waits a half-period, samples the input and then pulses the clock. The device only ever answers in its low four bits, so a read keeps only the low nibble. Chip-enable, register addressing and time formatting are left to the sequencer.

Top module: `tws_byte_shifter`

## Requirements
- R1: Out of reset, `scl_o` is high, and `sd_oe_o`, `busy_o`, `done_o` are low with `rdata_o` zero. While idle, `scl_o` stays high.
- R2: A write sends exactly 8 bits of `wdata_i` on `sdo_o`, bit 7 first and bit 0 last, one bit per falling edge of `scl_o`.
- R3: For each written bit, `sdo_o` is set while `scl_o` is high. `sdo_o` does not change while `scl_o` is low, and each low phase of `scl_o` lasts exactly one half-period.
- R4: `sd_oe_o` rises while `scl_o` is still high, after bit 7 is already on `sdo_o` and before the first falling edge. It stays high for all 8 bits, is low again when `done_o` pulses, and is never high during a read.
- R5: A read (`read_i`=1) gives 8 clock pulses. Each bit of `sdi_i` is sampled after one half-period with `scl_o` high, before that bit's falling edge, first-sampled bit as most significant.
- R6: After a read, `rdata_o[7:4]` is 0 and `rdata_o[3:0]` holds the last four sampled bits (5th sample in bit 3, 8th in bit 0). Nothing from an earlier read remains.
- R7: `busy_o` is high from the cycle after an accepted start until `done_o`. `done_o` is a single-cycle pulse during which `busy_o` is already low. A start pulse while busy has no effect on the current byte and produces no extra transfer.
- R8: The half-period is ceil(HALF_NS × CLK_MHZ / 1000) clock cycles, which is 88 cycles at the defaults of 125 MHz and 700 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Single-cycle transfer request |
| read_i | input | 1 | Direction for the request: 1 read, 0 write |
| wdata_i | input | 8 | Byte to send on a write |
| sdi_i | input | 1 | Data wire as seen from the device |
| scl_o | output | 1 | Serial clock, idles high |
| sdo_o | output | 1 | Data value driven toward the device |
| sd_oe_o | output | 1 | Output enable for the shared data wire |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Received value, upper nibble zero |

## Verification
The hardest cases to reach are a start request that arrives in the middle of a byte, and a read that follows one with the opposite bit values. A stale-bit or re-trigger fault is visible only in those cases. The driver issues a second start with a different byte and direction deep inside a write. The scoreboard then requires exactly one result, equal to the original byte. Reads of all-ones followed by all-zeros patterns expose leftover received bits. The enable ordering is checked at the instant the enable rises, against the value already on the data output.

// File: rtl/tws_pkg.sv
package tws_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PLACE,
      ST_ENABLE,
      ST_LEAD,
      ST_LOW,
      ST_HIGH
   } tws_state_e;
endpackage

// File: rtl/tws_half_timer.sv
module tws_half_timer #(
   parameter int HALF_CYC = 88
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic expired
);
   localparam int CNT_W = (HALF_CYC < 2) ? 1 : $clog2(HALF_CYC);
   localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(HALF_CYC - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (restart)
         cnt_q <= LOAD_VAL;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

   // R8: a restart always yields a full count before expiry
   a_r8_no_early_expire: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && HALF_CYC > 1) |=> !expired);
endmodule

// File: rtl/tws_shifter.sv
module tws_shifter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         shift_tx,
   input  logic         sample,
   input  logic         sdi,
   output logic         tx_msb,
   output logic [W-1:0] rx_val
);
   logic [W-1:0] tx_q;
   logic [W-1:0] rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q <= '0;
         rx_q <= '0;
      end else begin
         if (load)
            tx_q <= load_val;
         else if (shift_tx)
            tx_q <= {tx_q[W-2:0], 1'b0};
         if (load)
            rx_q <= '0;
         else if (sample)
            rx_q <= {rx_q[W-2:0], sdi};
      end
   end

   assign tx_msb = tx_q[W-1];
   assign rx_val = rx_q;
endmodule

// File: rtl/tws_byte_shifter.sv
module tws_byte_shifter #(
   parameter int CLK_MHZ = 125,
   parameter int HALF_NS = 700,
   parameter int DATA_W  = 8,
   parameter int KEEP_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              read_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              sdi_i,
   output logic              scl_o,
   output logic              sdo_o,
   output logic              sd_oe_o,
   output logic              busy_o,
   output logic              done_o,
   output logic [DATA_W-1:0] rdata_o
);
   import tws_pkg::*;

   localparam int HALF_CYC = (HALF_NS * CLK_MHZ + 999) / 1000;
   localparam int BIT_W    = $clog2(DATA_W);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

   initial begin
      assert (DATA_W >= 2) else $error("DATA_W must be at least 2");
      assert (KEEP_W >= 1 && KEEP_W <= DATA_W) else $error("KEEP_W out of range");
      assert (HALF_CYC >= 1) else $error("half-period rounds to zero cycles");
   end

   tws_state_e       state_q, state_d;
   logic [BIT_W-1:0] bit_q;
   logic             dir_q;
   logic             oe_q, busy_q, done_q;
   logic [DATA_W-1:0] rdata_q;
   logic             expired, restart;
   logic             accept, last_bit, finish, shift_tx, sample;
   logic             tx_msb;
   logic [DATA_W-1:0] rx_val, kept;

   assign accept   = (state_q == ST_IDLE) && start_i;
   assign last_bit = (bit_q == LAST_BIT);
   assign finish   = (state_q == ST_HIGH) && expired && last_bit;
   assign shift_tx = (state_q == ST_HIGH) && expired && !last_bit && !dir_q;
   assign sample   = (state_q == ST_LEAD) && expired;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:   if (start_i) state_d = read_i ? ST_LEAD : ST_PLACE;
         ST_PLACE:  state_d = (bit_q == '0) ? ST_ENABLE : ST_LOW;
         ST_ENABLE: state_d = ST_LOW;
         ST_LEAD:   if (expired) state_d = ST_LOW;
         ST_LOW:    if (expired) state_d = ST_HIGH;
         ST_HIGH:   if (expired)
                       state_d = last_bit ? ST_IDLE : (dir_q ? ST_LEAD : ST_PLACE);
         default:   state_d = ST_IDLE;
      endcase
   end

   assign restart = (state_d != state_q) &&
                    (state_d == ST_LEAD || state_d == ST_LOW || state_d == ST_HIGH);

   tws_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .expired (expired)
   );

   tws_shifter #(.W(DATA_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val (read_i ? '0 : wdata_i),
      .shift_tx (shift_tx),
      .sample   (sample),
      .sdi      (sdi_i),
      .tx_msb   (tx_msb),
      .rx_val   (rx_val)
   );

   generate
      if (KEEP_W == DATA_W) begin : g_keep_all
         assign kept = rx_val;
      end else begin : g_keep_low
         assign kept = {{(DATA_W-KEEP_W){1'b0}}, rx_val[KEEP_W-1:0]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         bit_q   <= '0;
         dir_q   <= 1'b0;
         oe_q    <= 1'b0;
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         rdata_q <= '0;
      end else begin
         state_q <= state_d;
         done_q  <= finish;
         if (accept) begin
            bit_q  <= '0;
            dir_q  <= read_i;
            busy_q <= 1'b1;
         end else if ((state_q == ST_HIGH) && expired && !last_bit) begin
            bit_q <= bit_q + 1'b1;
         end
         if ((state_q == ST_PLACE) && (bit_q == '0))
            oe_q <= 1'b1;
         if (finish) begin
            oe_q   <= 1'b0;
            busy_q <= 1'b0;
            if (dir_q) rdata_q <= kept;
         end
      end
   end

   assign scl_o   = (state_q != ST_LOW);
   assign sdo_o   = tx_msb;
   assign sd_oe_o = oe_q;
   assign busy_o  = busy_q;
   assign done_o  = done_q;
   assign rdata_o = rdata_q;

   // R1: clock parked high whenever no transfer is running
   a_r1_idle_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> scl_o);
   // R3: data never moves during a low clock phase
   a_r3_data_steady_low: assert property (@(posedge clk) disable iff (!rst_n)
      !scl_o |-> $stable(sdo_o));
   // R4: enable only inside a transfer, and it rises with the clock still high
   a_r4_oe_in_transfer: assert property (@(posedge clk) disable iff (!rst_n)
      sd_oe_o |-> busy_o);
   a_r4_oe_before_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sd_oe_o) |-> scl_o);
   // R7: done is one cycle long and marks the end of busy
   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o)));
endmodule

// File: tb/tb_tws_byte_shifter.sv
`timescale 1ns/1ps
module tb_tws_byte_shifter;
   localparam int HALF = (700 * 125 + 999) / 1000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0, read_i = 1'b0, sdi_i = 1'b0;
   logic [7:0] wdata_i = 8'h00;
   logic scl_o, sdo_o, sd_oe_o, busy_o, done_o;
   logic [7:0] rdata_o;

   always #4 clk = ~clk;

   tws_byte_shifter dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .read_i(read_i),
      .wdata_i(wdata_i), .sdi_i(sdi_i), .scl_o(scl_o), .sdo_o(sdo_o),
      .sd_oe_o(sd_oe_o), .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o)
   );

   int checks = 0, errors = 0, dones = 0;
   bit finished = 1'b0;
   logic [8:0] exp_q[$];

   logic       cur_read = 1'b0;
   logic [7:0] pattern = 8'h00;
   int         rd_idx = 0;
   logic [7:0] cap = 8'h00;
   int         cap_n = 0;
   logic [7:0] cur_wbyte = 8'h00;

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // device model: present read bits, advancing on each rising clock edge
   always @(posedge scl_o) if (cur_read && busy_o) rd_idx++;
   always_comb sdi_i = (rd_idx < 8) ? pattern[7 - rd_idx] : 1'b0;

   // write capture at each falling clock edge (R2, R4 and R5 enable check)
   always @(negedge scl_o) begin
      if (!cur_read) begin
         cap = {cap[6:0], sdo_o};
         cap_n++;
         chk(sd_oe_o === 1'b1, "R4 oe high at write falling edge", sd_oe_o, 1);
      end else begin
         chk(sd_oe_o === 1'b0, "R4 oe low during read", sd_oe_o, 0);
      end
   end

   // R4: on enable rise, bit 7 already on the wire and clock high
   always @(posedge sd_oe_o) begin
      chk(sdo_o === cur_wbyte[7], "R4 bit7 placed before enable", sdo_o, cur_wbyte[7]);
      chk(scl_o === 1'b1, "R4 clock high at enable", scl_o, 1);
   end

   // R3/R8: low phase width
   int low_run = 0;
   always @(negedge clk) begin
      if (rst_n && !scl_o) low_run++;
      else if (low_run != 0) begin
         chk(low_run == HALF, "R3 R8 low phase length", low_run, HALF);
         low_run = 0;
      end
   end

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && done_o) begin
         logic [8:0] e;
         dones++;
         chk(busy_o === 1'b0, "R7 busy low at done", busy_o, 0);
         chk(sd_oe_o === 1'b0, "R4 oe released at done", sd_oe_o, 0);
         if (exp_q.size() == 0) begin
            chk(1'b0, "R7 unexpected done", dones, 0);
         end else begin
            e = exp_q.pop_front();
            if (e[8]) begin
               chk(rdata_o === e[7:0], "R5 R6 read result", rdata_o, e[7:0]);
            end else begin
               chk(cap === e[7:0], "R2 written byte", cap, e[7:0]);
               chk(cap_n == 8, "R2 bit count", cap_n, 8);
            end
         end
      end
   end

   task automatic issue(input logic rd, input logic [7:0] wb, input logic [7:0] pat);
      while (busy_o) @(negedge clk);
      @(negedge clk);
      cur_read = rd; pattern = pat; rd_idx = 0; cap = 8'h00; cap_n = 0;
      if (!rd) cur_wbyte = wb;
      exp_q.push_back(rd ? {1'b1, 4'h0, pat[3:0]} : {1'b0, wb});
      read_i = rd; wdata_i = wb; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o === 1'b1, "R7 busy after start", busy_o, 1);
   endtask

   task automatic wait_done();
      while (!done_o) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(scl_o === 1'b1, "R1 scl reset", scl_o, 1);
      chk(sd_oe_o === 1'b0, "R1 oe reset", sd_oe_o, 0);
      chk(busy_o === 1'b0, "R1 busy reset", busy_o, 0);
      chk(done_o === 1'b0, "R1 done reset", done_o, 0);
      chk(rdata_o === 8'h00, "R1 rdata reset", rdata_o, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(scl_o === 1'b1, "R1 scl idle high", scl_o, 1);

      // R2 writes, several patterns
      issue(1'b0, 8'hA5, 8'h00); wait_done();
      issue(1'b0, 8'h80, 8'h00); wait_done();
      issue(1'b0, 8'h01, 8'h00); wait_done();
      issue(1'b0, 8'hFF, 8'h00); wait_done();

      // R5 R6 reads, all-ones then all-zeros to catch stale bits
      issue(1'b1, 8'h00, 8'hFF); wait_done();
      issue(1'b1, 8'hFF, 8'h00); wait_done();
      issue(1'b1, 8'h00, 8'h3C); wait_done();
      issue(1'b1, 8'h00, 8'hC9); wait_done();

      // R7 start while busy is ignored
      issue(1'b0, 8'h5A, 8'h00);
      repeat (300) @(negedge clk);
      read_i = 1'b1; wdata_i = 8'hC3; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o === 1'b1, "R7 still busy after ignored start", busy_o, 1);
      wait_done();
      repeat (3 * HALF) @(negedge clk);
      chk(dones == 9, "R7 done count", dones, 9);
      chk(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);
      chk(scl_o === 1'b1 && sd_oe_o === 1'b0, "R1 idle after run", {scl_o, sd_oe_o}, 2);
      finish_run();
   end
endmodule